// File: doc/BRIEF.md
# Look-Ahead Single-Clock FIFO

This block is a single-clock queue whose storage array only returns data on a clock edge. An output stage sits in front of the array and is filled ahead of time, so the oldest stored word is already on the read data bus, with a valid flag, before the consumer asks for it. A read request takes the word that is showing. In the same cycle the stage asks the array for the next entry, so a run of read requests drains one word per clock.

The producer offers a word with a write request and sees a ready flag that says whether room is left. The consumer sees a valid flag and the head word, and asserts a read request to take it. An occupancy output counts every word held, including the one in the output stage. The total capacity is therefore one more than the array depth. When the queue holds exactly one word and a read and a write arrive together, the new word goes straight into the output stage, so the valid flag does not drop.

Top module: `fwft_fifo`

## Requirements
- R1: After a synchronous active-high reset, `rd_valid` is 0, `wr_ready` is 1 and `level` is 0.
- R2: A word written into an empty FIFO is not flagged valid after the first clock edge. It is flagged valid, and shown on `rd_data`, after the second edge, with no read request needed.
- R3: Words leave in the order they were accepted, with all `DATA_W` bits (33 by default) unchanged.
- R4: When two or more words are held, a read request accepted in one cycle leaves `rd_valid` high in the next cycle, showing the following word. Consecutive reads therefore run at one word per clock.
- R5: A read request while `rd_valid` is 0 is ignored: `level`, the flags and the later output order are unchanged.
- R6: A write request while `wr_ready` is 0 is ignored: the word is not stored and `level` does not change.
- R7: When exactly one word is held and a read and a write are accepted in the same cycle, `rd_valid` stays 1 and the newly written word is on `rd_data` in the next cycle.
- R8: `level` equals the number of accepted words not yet read, including the word in the output stage. `wr_ready` is 0 exactly when `level` equals `DEPTH+1`.
- R9: While `rd_valid` is 1 and no read request is given, `rd_valid` and `rd_data` hold their values.
- R10: The FIFO accepts `DEPTH+1` words without a read and returns all of them in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Write request; the word is accepted when `wr_ready` is 1 |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | Room is available for a write |
| rd_req | input | 1 | Read request; takes the head word when `rd_valid` is 1 |
| rd_valid | output | 1 | The head word on `rd_data` is valid |
| rd_data | output | DATA_W | Head word, shown before it is requested |
| level | output | $clog2(DEPTH+2) | Number of words held, output stage included |

## Verification
The hardest state to reach is a read and a write in the same cycle while exactly one word is held and the array is empty. Only in this state does the write skip the array and land in the output stage. The bench reaches it on purpose: it writes one word, waits two edges for it to become valid, and then asserts both requests together. It does this again right after draining a full FIFO, and a long mixed stream with random write and read pressure hits the state many more times. A second hard spot is the single cycle after the first write into an empty FIFO, when a word is stored but not yet valid. The bench gives a read request exactly there to confirm that it is ignored.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

    // Which register is driving the head word.
    typedef enum logic {
        SRC_ARRAY  = 1'b0,
        SRC_BYPASS = 1'b1
    } head_src_e;

    // Per-cycle decisions taken by the top-level control.
    typedef struct packed {
        logic push;    // word goes into the storage array
        logic fetch;   // array read issued, head reloads next edge
        logic bypass;  // write word goes straight into the head stage
        logic pop;     // consumer takes the head word
    } fwft_ctl_t;

    // Circular index increment for any depth.
    function automatic int next_idx(input int idx, input int depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/fwft_store.sv
module fwft_store #(
    parameter int DATA_W = 33,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_word;
        end
    end

    // Registered read port: data only after an edge
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/fwft_ptrs.sv
module fwft_ptrs
    import fwft_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          fetch,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] mem_count,
    output logic          mem_full,
    output logic          mem_empty
);

    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= AW'(next_idx(int'(wr_ptr_q), DEPTH));
            end
            if (fetch) begin
                rd_ptr_q <= AW'(next_idx(int'(rd_ptr_q), DEPTH));
            end
            case ({push, fetch})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign wr_addr   = wr_ptr_q;
    assign rd_addr   = rd_ptr_q;
    assign mem_count = cnt_q;
    assign mem_full  = (cnt_q == CW'(DEPTH));
    assign mem_empty = (cnt_q == '0);

    // Array is never written past its depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        mem_full |-> !push);

    // Array is never read when it holds nothing
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        mem_empty |-> !fetch);

    // Count never exceeds the array depth
    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/fwft_head.sv
module fwft_head
    import fwft_pkg::*;
#(
    parameter int DATA_W = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  fwft_ctl_t         ctl,
    input  logic [DATA_W-1:0] byp_word,
    input  logic [DATA_W-1:0] arr_word,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_word
);

    logic              valid_q;
    head_src_e         src_q;
    logic [DATA_W-1:0] byp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            src_q   <= SRC_ARRAY;
        end else begin
            if (ctl.fetch || ctl.bypass) begin
                valid_q <= 1'b1;
            end else if (ctl.pop) begin
                valid_q <= 1'b0;
            end
            if (ctl.bypass) begin
                src_q <= SRC_BYPASS;
            end else if (ctl.fetch) begin
                src_q <= SRC_ARRAY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ctl.bypass) begin
            byp_q <= byp_word;
        end
    end

    assign head_valid = valid_q;
    assign head_word  = (src_q == SRC_BYPASS) ? byp_q : arr_word;

    // Only one source may reload the head in a cycle
    p_single_load_r7: assert property (@(posedge clk) disable iff (rst)
        !(ctl.fetch && ctl.bypass));

    // A head not taken stays put
    p_head_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ctl.pop) |=> (valid_q && $stable(head_word)));

    // The head is never reloaded while an untaken word sits there
    p_no_clobber_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ctl.pop) |-> !(ctl.fetch || ctl.bypass));

endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo
    import fwft_pkg::*;
#(
    parameter int DATA_W = 33,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int CAP   = DEPTH + 1,
    localparam int LW    = $clog2(DEPTH + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [LW-1:0]     level
);

    logic [AW-1:0]     wr_addr, rd_addr;
    logic [CW-1:0]     mem_count;
    logic              mem_full, mem_empty;
    logic              head_valid;
    logic [DATA_W-1:0] arr_word, head_word;
    logic              wr_fire, rd_fire;
    fwft_ctl_t         ctl;

    assign wr_fire = wr_req && !mem_full;
    assign rd_fire = rd_req && head_valid;

    always_comb begin
        ctl        = '0;
        ctl.pop    = rd_fire;
        ctl.bypass = wr_fire && rd_fire && mem_empty;
        ctl.push   = wr_fire && !ctl.bypass;
        ctl.fetch  = !mem_empty && (!head_valid || rd_fire);
    end

    fwft_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push     (ctl.push),
        .fetch    (ctl.fetch),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .mem_count(mem_count),
        .mem_full (mem_full),
        .mem_empty(mem_empty)
    );

    fwft_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .wr_en  (ctl.push),
        .wr_addr(wr_addr),
        .wr_word(wr_data),
        .rd_en  (ctl.fetch),
        .rd_addr(rd_addr),
        .rd_word(arr_word)
    );

    fwft_head #(.DATA_W(DATA_W)) u_head (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .byp_word  (wr_data),
        .arr_word  (arr_word),
        .head_valid(head_valid),
        .head_word (head_word)
    );

    assign wr_ready = !mem_full;
    assign rd_valid = head_valid;
    assign rd_data  = head_word;
    assign level    = LW'(mem_count) + LW'(head_valid);

    // First word into an empty FIFO is not valid after one edge
    p_first_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && wr_req) |=> !rd_valid);

    // Back-to-back reads sustain when two or more words are held
    p_stream_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid && level >= LW'(2)) |=> rd_valid);

    // Read while not readable leaves occupancy alone
    p_ignore_read_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid && !wr_req) |=> (level == $past(level)));

    // Write while full leaves occupancy alone
    p_ignore_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ready && !rd_req) |=> (level == $past(level)));

    // One word held, read and write together: new word falls through
    p_fall_through_r7: assert property (@(posedge clk) disable iff (rst)
        (level == LW'(1) && rd_valid && rd_req && wr_req)
            |=> (rd_valid && rd_data == $past(wr_data)));

    // Full flag matches total occupancy including the head stage
    p_full_level_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr_ready) == (level == LW'(CAP)));

endmodule

// File: tb/sim_fwft_fifo.sv
module sim_fwft_fifo;

    localparam int DATA_W = 33;
    localparam int DEPTH  = 8;
    localparam int CAP    = DEPTH + 1;
    localparam int LW     = $clog2(DEPTH + 2);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_req = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_ready;
    logic              rd_req = 1'b0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [LW-1:0]     level;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural model state
    logic [DATA_W-1:0] q[$];
    bit                fresh = 1'b0;  // word just entered an empty FIFO

    always #2 clk = ~clk;

    fwft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .wr_data (wr_data),
        .wr_ready(wr_ready),
        .rd_req  (rd_req),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .level   (level)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    function automatic bit model_valid();
        return (q.size() > 0) && !fresh;
    endfunction

    // Compare all outputs with the model (called away from the edge).
    task automatic compare(input string tag);
        check(tag, "rd_valid", 64'(rd_valid), 64'(model_valid()));
        check(tag, "wr_ready", 64'(wr_ready), 64'(q.size() < CAP));
        check(tag, "level", 64'(level), 64'(q.size()));
        if (model_valid()) begin
            check(tag, "rd_data", 64'(rd_data), 64'(q[0]));
        end
    endtask

    // One clock: compare, drive, advance model and design together.
    task automatic step(input string tag, input bit w,
                        input logic [DATA_W-1:0] d, input bit r);
        bit rf, wf, nf;
        compare(tag);
        wr_req  = w;
        wr_data = d;
        rd_req  = r;
        rf = r && model_valid();
        wf = w && (q.size() < CAP);
        nf = wf && (q.size() == 0);
        @(posedge clk);
        if (rf) void'(q.pop_front());
        if (wf) q.push_back(d);
        fresh = nf;
        @(negedge clk);
        wr_req = 1'b0;
        rd_req = 1'b0;
    endtask

    function automatic logic [DATA_W-1:0] pat(input int n);
        return {n[0], 32'(n * 32'h9E37_79B9) ^ 32'hA5A5_0000};
    endfunction

    initial begin
        // Watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1", "rd_valid", 64'(rd_valid), 64'd0);
        check("R1", "wr_ready", 64'(wr_ready), 64'd1);
        check("R1", "level", 64'(level), 64'd0);

        // R5: read on empty FIFO
        step("R5", 1'b0, '0, 1'b1);
        step("R5", 1'b0, '0, 1'b1);

        // R2: single write, no read; latency of two edges
        step("R2", 1'b1, pat(1), 1'b0);
        check("R2", "valid after one edge", 64'(rd_valid), 64'd0);
        // R5: read request in the not-yet-valid cycle is ignored
        step("R5", 1'b0, '0, 1'b1);
        check("R2", "valid after two edges", 64'(rd_valid), 64'd1);
        check("R2", "head word", 64'(rd_data), 64'(pat(1)));
        // R9: head holds while not taken
        for (int i = 0; i < 3; i++) step("R9", 1'b0, '0, 1'b0);
        check("R9", "head held", 64'(rd_data), 64'(pat(1)));

        // R7: one word held, read and write together
        step("R7", 1'b1, pat(2), 1'b1);
        check("R7", "valid kept", 64'(rd_valid), 64'd1);
        check("R7", "fell through", 64'(rd_data), 64'(pat(2)));
        step("R7", 1'b0, '0, 1'b1);

        // R4/R3: several words then back-to-back reads
        for (int i = 0; i < 5; i++) step("R3", 1'b1, pat(10 + i), 1'b0);
        step("R3", 1'b0, '0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            if (i < 4) check("R4", "valid while streaming", 64'(rd_valid), 64'd1);
            step("R4", 1'b0, '0, 1'b1);
        end

        // R10/R8/R6: fill to capacity, overfill, drain
        for (int i = 0; i < CAP; i++) step("R10", 1'b1, pat(100 + i), 1'b0);
        check("R8", "full flag", 64'(wr_ready), 64'd0);
        check("R8", "level at capacity", 64'(level), 64'(CAP));
        step("R6", 1'b1, pat(999), 1'b0);
        step("R6", 1'b1, pat(998), 1'b0);
        check("R6", "level unchanged", 64'(level), 64'(CAP));
        for (int i = 0; i < CAP; i++) begin
            check("R10", "drain order", 64'(rd_data), 64'(pat(100 + i)));
            step("R10", 1'b0, '0, 1'b1);
        end
        check("R10", "empty after drain", 64'(rd_valid), 64'd0);

        // R7 again straight after drain
        step("R7", 1'b1, pat(300), 1'b0);
        step("R7", 1'b0, '0, 1'b0);
        step("R7", 1'b1, pat(301), 1'b1);
        check("R7", "second fall through", 64'(rd_data), 64'(pat(301)));

        // R3: long mixed stream under varying pressure
        for (int i = 0; i < 4000; i++) begin
            int phase = i / 1000;
            bit w = (phase == 1) ? ($urandom % 4 != 0) : ($urandom % 2 == 1);
            bit r = (phase == 2) ? ($urandom % 4 != 0) : ($urandom % 2 == 1);
            logic [DATA_W-1:0] d = {1'($urandom), 32'($urandom)};
            step("R3", w, d, r);
        end
        compare("R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule